// File: doc/BRIEF.md
# Byte-Packed Operand Scratchpad

This block is a random-access holding store for operands whose lifetime is long or unknown. A spill operation takes an operand of 1, 2, 4 or 8 bytes, together with a not-a-result marker, and writes it at a byte offset given with the operation. Each stored entry begins with a one-byte header that records its own size and marker. The payload bytes follow the header at once. Entries of different sizes therefore sit back to back with no padding to the largest size, and no table maps entry numbers to positions.

A fill operation names only the start offset of an entry. The block reads the header found there, learns the operand size from it, and returns the payload. The payload is zero-extended to 64 bits and comes with its size code and not-a-result marker. A fill always completes in a fixed number of cycles, however long the value has been held. The block accepts one spill and one fill in every cycle. An access whose extent runs past the configured capacity is flagged and writes nothing.

Top module: `scratch_pad`

## Requirements
- R1: While reset is low, and after it, `rd_valid` and `sp_err` are 0. Reset clears every byte to zero, so a fill of a location never spilled returns `rd_nar`=1, `rd_code`=0, `rd_data`=0 and `rd_err`=0, provided its extent fits.
- R2: A spill at offset `o` with size code `c` (0→1, 1→2, 2→4, 3→8 bytes) writes a header byte at `o`. The header holds bits [1:0]=`c`, bit 2=1 for a real result or 0 for not-a-result, and bits [7:3]=0. The spill then writes the low `1<<c` bytes of `sp_data`, least significant byte first, at `o+1` onward.
- R3: A fill takes the size from the header at its offset and never from the request. `rd_data` carries the payload bytes in their stored order, and every bit above the payload size is zero.
- R4: Addressing works at byte granularity. Entries placed back to back do not disturb one another. A fill at any offset treats the byte found there as a header, including a byte that lies inside another entry's payload.
- R5: The fill result appears on the outputs after the second rising clock edge following the cycle in which `fl_valid` is presented, and not after the first. The same holds however many cycles the value has been held.
- R6: A spill with `o+1+(1<<c)` greater than `SIZE_BYTES` sets `sp_err` after the next rising edge and leaves every stored byte unchanged.
- R7: A fill whose header offset, or whose offset plus 1 plus the header's payload size, runs past `SIZE_BYTES` returns `rd_err`=1, `rd_nar`=1, `rd_code`=0 and `rd_data`=0.
- R8: A fill presented in the same cycle as a spill returns the contents as they stand after that spill.
- R9: Fills presented on consecutive cycles each return their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_valid | input | 1 | Spill request this cycle |
| sp_off | input | OFF_W | Spill start byte offset |
| sp_code | input | 2 | Spill size code |
| sp_nar | input | 1 | Spilled operand is not-a-result |
| sp_data | input | 64 | Spilled operand, low bytes used |
| sp_err | output | 1 | Previous spill was out of bounds |
| fl_valid | input | 1 | Fill request this cycle |
| fl_off | input | OFF_W | Fill start byte offset |
| rd_valid | output | 1 | Fill result valid |
| rd_data | output | 64 | Fill payload, zero-extended |
| rd_code | output | 2 | Fill size code from header |
| rd_nar | output | 1 | Fill result is not-a-result |
| rd_err | output | 1 | Fill was out of bounds |

## Verification
The bench spills every size code at every offset, from zero to two bytes past the end. Each spill is followed by a fill at the same offset, which separates correct header encoding and little-endian placement from errors in bounds arithmetic at the top edge. It then fills every offset once, so that entry residues and reads at misaligned payload bytes expose any packing or overlap mistakes. Separate sequences cover the following cases:
- a spill and a fill in the same cycle, which tells write-first forwarding apart from stale reads;
- back-to-back fills, which show each result stays in its own pipeline slot;
- a value held for a long idle gap, which must come back with unchanged latency.

// File: rtl/scr_pkg.sv
// Shared constants and helpers for the scratchpad.
// Assumes a 64-bit operand and a 2-bit size code.
package scr_pkg;
    localparam int DATA_W    = 64;
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int WIN       = MAX_BYTES + 1;   // header plus largest payload
    localparam int HDR_NB    = 1;

    typedef logic [1:0] wcode_t;

    // Payload bytes named by a size code.
    function automatic int unsigned code_bytes(input wcode_t c);
        return 32'd1 << c;
    endfunction
endpackage

// File: rtl/scr_extent.sv
// Bounds check: does an entry of a given size code starting at off fit?
// Assumes off and the size stay well under 2**(OFF_W+4).
module scr_extent #(
    parameter int SIZE_BYTES = 64,
    parameter int OFF_W      = 7
) (
    input  logic [OFF_W-1:0]   off,
    input  scr_pkg::wcode_t    code,
    output logic               fits
);
    localparam int EXT_W = OFF_W + 4;
    localparam logic [EXT_W-1:0] LIMIT = EXT_W'(SIZE_BYTES);

    logic [EXT_W-1:0] last_excl;

    // End of the extent: header byte plus payload bytes.
    always_comb begin
        last_excl = EXT_W'(off) + EXT_W'(scr_pkg::HDR_NB)
                  + (EXT_W'(1) << code);
        fits      = (last_excl <= LIMIT);
    end
endmodule

// File: rtl/scr_bytes.sv
// Byte array with reset-to-zero cells. One write port covers up to WIN
// consecutive bytes. One read port returns a header and a payload window.
// Assumes the writer has already checked bounds; reads past the end return 0.
module scr_bytes #(
    parameter int SIZE_BYTES = 64,
    parameter int OFF_W      = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [OFF_W-1:0]             wr_off,
    input  logic [3:0]                   wr_len,
    input  logic [scr_pkg::WIN-1:0][7:0] wr_win,
    input  logic [OFF_W-1:0]             rd_off,
    output logic [2:0]                   rd_hdr,
    output logic [scr_pkg::MAX_BYTES-1:0][7:0] rd_pay
);
    localparam int EXT_W = OFF_W + 4;
    localparam int AW    = (SIZE_BYTES > 1) ? $clog2(SIZE_BYTES) : 1;
    localparam logic [EXT_W-1:0] LIMIT = EXT_W'(SIZE_BYTES);

    logic [7:0]                   mem [SIZE_BYTES];
    logic [SIZE_BYTES-1:0]        hit;
    logic [SIZE_BYTES-1:0][7:0]   pick;
    logic [EXT_W-1:0]             rel;
    logic [EXT_W-1:0]             hidx;

    // Per-byte write decode: is the byte inside the write window, and which lane feeds it.
    always_comb begin
        rel  = '0;
        hit  = '0;
        pick = '0;
        for (int i = 0; i < SIZE_BYTES; i++) begin
            rel     = EXT_W'(i) - EXT_W'(wr_off);
            hit[i]  = wr_en && (EXT_W'(wr_off) <= EXT_W'(i))
                    && (rel < EXT_W'(wr_len));
            for (int k = 0; k < scr_pkg::WIN; k++) begin
                if (rel == EXT_W'(k)) pick[i] = wr_win[k];
            end
        end
    end

    // Storage cells: zeroed by reset, written where the decode hits.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SIZE_BYTES; i++) begin
            if (!rst_n)      mem[i] <= '0;
            else if (hit[i]) mem[i] <= pick[i];
        end
    end

    // Header read: only the size and marker bits are needed.
    always_comb begin
        hidx   = EXT_W'(rd_off);
        rd_hdr = (hidx < LIMIT) ? mem[hidx[AW-1:0]][2:0] : 3'b000;
    end

    // Payload read window following the header.
    for (genvar k = 0; k < scr_pkg::MAX_BYTES; k++) begin : g_pay
        logic [EXT_W-1:0] pidx;
        assign pidx      = EXT_W'(rd_off) + EXT_W'(k + 1);
        assign rd_pay[k] = (pidx < LIMIT) ? mem[pidx[AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/scr_fill.sv
// Two-stage fill pipeline. Stage 1 registers the request and reads the array
// after any same-cycle spill has landed. Stage 2 registers the decoded result.
// Assumes the array read is combinational from rd_off.
module scr_fill #(
    parameter int SIZE_BYTES = 64,
    parameter int OFF_W      = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [OFF_W-1:0]           in_off,
    output logic [OFF_W-1:0]           rd_off,
    input  logic [2:0]                 rd_hdr,
    input  logic [scr_pkg::MAX_BYTES-1:0][7:0] rd_pay,
    output logic                       out_valid,
    output logic [scr_pkg::DATA_W-1:0] out_data,
    output scr_pkg::wcode_t            out_code,
    output logic                       out_nar,
    output logic                       out_err
);
    logic                       s1_valid;
    logic [OFF_W-1:0]           s1_off;
    logic                       fits;
    logic [scr_pkg::DATA_W-1:0] payload;
    int unsigned                nb;

    scr_extent #(.SIZE_BYTES(SIZE_BYTES), .OFF_W(OFF_W)) i_ext (
        .off  (s1_off),
        .code (rd_hdr[1:0]),
        .fits (fits)
    );

    assign rd_off = s1_off;

    // Stage 1: hold the request for the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_off   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_off   <= in_off;
        end
    end

    // Rebuild the operand from the stored payload, zero above its size.
    always_comb begin
        nb      = scr_pkg::code_bytes(rd_hdr[1:0]);
        payload = '0;
        for (int k = 0; k < scr_pkg::MAX_BYTES; k++) begin
            if (k < int'(nb)) payload[k*8 +: 8] = rd_pay[k];
        end
    end

    // Stage 2: register the result; an out-of-bounds fill reads as not-a-result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_code  <= '0;
            out_nar   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_err   <= s1_valid && !fits;
            out_data  <= (s1_valid && fits) ? payload : '0;
            out_code  <= (s1_valid && fits) ? rd_hdr[1:0] : 2'b00;
            out_nar   <= s1_valid && (!fits || !rd_hdr[2]);
        end
    end
endmodule

// File: rtl/scratch_pad.sv
// Top of the byte-packed scratchpad. A spill builds a header-plus-payload
// window and writes it when it fits. A fill runs through a two-stage pipeline.
// Assumes at most one spill and one fill per cycle; no handshake.
module scratch_pad #(
    parameter int SIZE_BYTES = 64,
    parameter int OFF_W      = $clog2(SIZE_BYTES) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sp_valid,
    input  logic [OFF_W-1:0]           sp_off,
    input  logic [1:0]                 sp_code,
    input  logic                       sp_nar,
    input  logic [63:0]                sp_data,
    output logic                       sp_err,
    input  logic                       fl_valid,
    input  logic [OFF_W-1:0]           fl_off,
    output logic                       rd_valid,
    output logic [63:0]                rd_data,
    output logic [1:0]                 rd_code,
    output logic                       rd_nar,
    output logic                       rd_err
);
    logic                                 sp_fits;
    logic                                 wr_en;
    logic [3:0]                           wr_len;
    logic [scr_pkg::WIN-1:0][7:0]         wr_win;
    logic [OFF_W-1:0]                     rd_off;
    logic [2:0]                           rd_hdr;
    logic [scr_pkg::MAX_BYTES-1:0][7:0]   rd_pay;

    scr_extent #(.SIZE_BYTES(SIZE_BYTES), .OFF_W(OFF_W)) i_sp_ext (
        .off  (sp_off),
        .code (sp_code),
        .fits (sp_fits)
    );

    // Spill window: header byte then little-endian payload.
    always_comb begin
        wr_en     = sp_valid && sp_fits;
        wr_len    = 4'(scr_pkg::HDR_NB) + (4'd1 << sp_code);
        wr_win[0] = {5'b00000, !sp_nar, sp_code};
        for (int k = 0; k < scr_pkg::MAX_BYTES; k++) begin
            wr_win[k+1] = sp_data[k*8 +: 8];
        end
    end

    // Spill bounds flag, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_err <= 1'b0;
        else        sp_err <= sp_valid && !sp_fits;
    end

    scr_bytes #(.SIZE_BYTES(SIZE_BYTES), .OFF_W(OFF_W)) i_bytes (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_off (sp_off),
        .wr_len (wr_len),
        .wr_win (wr_win),
        .rd_off (rd_off),
        .rd_hdr (rd_hdr),
        .rd_pay (rd_pay)
    );

    scr_fill #(.SIZE_BYTES(SIZE_BYTES), .OFF_W(OFF_W)) i_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (fl_valid),
        .in_off    (fl_off),
        .rd_off    (rd_off),
        .rd_hdr    (rd_hdr),
        .rd_pay    (rd_pay),
        .out_valid (rd_valid),
        .out_data  (rd_data),
        .out_code  (rd_code),
        .out_nar   (rd_nar),
        .out_err   (rd_err)
    );
endmodule

// File: rtl/scr_checks.sv
// Assertion checker for scratch_pad, attached with bind below.
// Assumes it sees the top-level ports only.
module scr_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        sp_valid,
    input logic        sp_err,
    input logic        fl_valid,
    input logic        rd_valid,
    input logic [63:0] rd_data,
    input logic [1:0]  rd_code,
    input logic        rd_nar,
    input logic        rd_err
);
    // R1: reset leaves both result flags low.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !sp_err));

    // R5: a result only follows a fill presented two edges earlier.
    assert_fill_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(fl_valid, 2));

    // R6: a bounds error only follows a spill.
    assert_spill_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_err |-> $past(sp_valid));

    // R7: an out-of-bounds fill reads as an empty not-a-result.
    assert_oob_fill_nar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |-> (rd_nar && rd_data == 64'd0 && rd_code == 2'd0));

    // R3: bits above the stored size are zero.
    assert_zero_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_err) |-> ((rd_data >> (7'd8 << rd_code)) == 64'd0));
endmodule

bind scratch_pad scr_checks i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_valid (sp_valid),
    .sp_err   (sp_err),
    .fl_valid (fl_valid),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_code  (rd_code),
    .rd_nar   (rd_nar),
    .rd_err   (rd_err)
);

// File: tb/test_scratch_pad.sv
// Self-checking bench: sweeps every offset and size code against a byte model.
module test_scratch_pad;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE       = 64;
    localparam int OW         = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sp_valid = 1'b0;
    logic [OW-1:0] sp_off = '0;
    logic [1:0]    sp_code = '0;
    logic          sp_nar = 1'b0;
    logic [63:0]   sp_data = '0;
    logic          sp_err;
    logic          fl_valid = 1'b0;
    logic [OW-1:0] fl_off = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic [1:0]    rd_code;
    logic          rd_nar;
    logic          rd_err;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl [SIZE];

    scratch_pad #(.SIZE_BYTES(SIZE), .OFF_W(OW)) i_scratch_pad (
        .clk(clk), .rst_n(rst_n),
        .sp_valid(sp_valid), .sp_off(sp_off), .sp_code(sp_code),
        .sp_nar(sp_nar), .sp_data(sp_data), .sp_err(sp_err),
        .fl_valid(fl_valid), .fl_off(fl_off),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_code(rd_code),
        .rd_nar(rd_nar), .rd_err(rd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Model of a spill per R2/R6: returns the expected error flag.
    function automatic logic mdl_spill(input int off, input int code, input logic nar,
                                       input logic [63:0] d);
        int nb = 1 << code;
        if (off + 1 + nb > SIZE) return 1'b1;
        mdl[off] = {5'b0, !nar, code[1:0]};
        for (int k = 0; k < nb; k++) mdl[off+1+k] = d[k*8 +: 8];
        return 1'b0;
    endfunction

    // Expected fill per R3/R4/R7, packed as {data, code, nar, err}.
    function automatic logic [67:0] mdl_fill(input int off);
        logic [7:0]  h;
        logic [63:0] d = '0;
        int nb;
        h  = (off < SIZE) ? mdl[off] : 8'h00;
        nb = 1 << h[1:0];
        if (off + 1 + nb > SIZE) return {64'd0, 2'd0, 1'b1, 1'b1};
        for (int k = 0; k < nb; k++) d[k*8 +: 8] = mdl[off+1+k];
        return {d, h[1:0], !h[2], 1'b0};
    endfunction

    function automatic logic [67:0] got_fill();
        return {rd_data, rd_code, rd_nar, rd_err};
    endfunction

    task automatic do_spill(input string tag, input int off, input int code,
                            input logic nar, input logic [63:0] d);
        logic e;
        @(negedge clk);
        sp_valid = 1'b1; sp_off = OW'(off); sp_code = code[1:0];
        sp_nar = nar; sp_data = d;
        e = mdl_spill(off, code, nar, d);
        @(negedge clk);
        sp_valid = 1'b0;
        chk(tag, 128'(sp_err), 128'(e));
    endtask

    task automatic do_fill(input string tag, input int off);
        logic [67:0] e;
        @(negedge clk);
        fl_valid = 1'b1; fl_off = OW'(off);
        e = mdl_fill(off);
        @(negedge clk);
        fl_valid = 1'b0;
        chk("R5 not early", 128'(rd_valid), 128'(0));
        @(negedge clk);
        chk(tag, 128'({rd_valid, got_fill()}), 128'({1'b1, e}));
    endtask

    // R8: spill and fill presented in the same cycle.
    task automatic do_both(input int soff, input int code, input logic [63:0] d, input int foff);
        logic        se;
        logic [67:0] fe;
        @(negedge clk);
        sp_valid = 1'b1; sp_off = OW'(soff); sp_code = code[1:0]; sp_nar = 1'b0; sp_data = d;
        fl_valid = 1'b1; fl_off = OW'(foff);
        se = mdl_spill(soff, code, 1'b0, d);
        fe = mdl_fill(foff);
        @(negedge clk);
        sp_valid = 1'b0; fl_valid = 1'b0;
        chk("R8 spill err", 128'(sp_err), 128'(se));
        @(negedge clk);
        chk("R8 forwarded fill", 128'({rd_valid, got_fill()}), 128'({1'b1, fe}));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [67:0] ea, eb, ec;
        for (int i = 0; i < SIZE; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 rd_valid in reset", 128'(rd_valid), 128'(0));
        chk("R1 sp_err in reset", 128'(sp_err), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_valid after reset", 128'(rd_valid), 128'(0));
        chk("R1 sp_err after reset", 128'(sp_err), 128'(0));
        do_fill("R1 unwritten 0", 0);
        do_fill("R1 unwritten 10", 10);
        do_fill("R1 unwritten 62", 62);
        do_fill("R7 unwritten last", SIZE - 1);
        do_fill("R7 past end", SIZE + 1);

        // R4: back-to-back packed entries of every size.
        do_spill("R4 spill a", 0, 3, 1'b0, 64'h1122_3344_5566_7788);
        do_spill("R4 spill b", 9, 0, 1'b1, 64'h0000_0000_0000_00AB);
        do_spill("R4 spill c", 11, 1, 1'b0, 64'hFFFF_FFFF_FFFF_CDEF);
        do_spill("R4 spill d", 14, 2, 1'b0, 64'h0000_0000_8765_4321);
        do_fill("R4 fill a", 0);
        do_fill("R4 fill b", 9);
        do_fill("R4 fill c", 11);
        do_fill("R4 fill d", 14);
        do_fill("R4 fill inside payload", 3);

        // R5: long hold keeps the same latency.
        do_spill("R5 spill", 20, 2, 1'b0, 64'hDEAD_BEEF);
        repeat (1000) @(negedge clk);
        do_fill("R5 long hold", 20);

        // R6: out-of-bounds spill leaves the array alone.
        do_spill("R6 fits", 56, 1, 1'b0, 64'h0000_0000_0000_A1B2);
        do_spill("R6 oob", 56, 3, 1'b0, 64'h0102_0304_0506_0708);
        do_fill("R6 unchanged", 56);
        do_spill("R6 edge fits", SIZE - 9, 3, 1'b0, 64'hC0FF_EE00_1234_5678);
        do_fill("R6 edge fill", SIZE - 9);

        // R8: same-cycle forwarding, exact and overlapping.
        do_both(30, 2, 64'h0000_0000_CAFE_F00D, 30);
        do_both(30, 3, 64'h0404_0404_0404_0404, 33);

        // R9: three fills on consecutive cycles.
        @(negedge clk); fl_valid = 1'b1; fl_off = OW'(0);  ea = mdl_fill(0);
        @(negedge clk); fl_off = OW'(14); eb = mdl_fill(14);
        @(negedge clk); fl_off = OW'(SIZE); ec = mdl_fill(SIZE);
        chk("R9 first", 128'({rd_valid, got_fill()}), 128'({1'b1, ea}));
        @(negedge clk); fl_valid = 1'b0;
        chk("R9 second", 128'({rd_valid, got_fill()}), 128'({1'b1, eb}));
        @(negedge clk);
        chk("R9 third", 128'({rd_valid, got_fill()}), 128'({1'b1, ec}));

        // R2 sweep: every size code at every offset, spill then fill.
        for (int off = 0; off < SIZE + 2; off++) begin
            for (int c = 0; c < 4; c++) begin
                logic [63:0] d;
                d = 64'hA5C3_0F1E_7B29_D684 ^ (64'(off) * 64'h0101_0101_0101_0101)
                  ^ (64'(c) << 61);
                do_spill("R2 sweep spill err", off, c, ((off + c) % 5) == 0, d);
                do_fill("R2 sweep fill", off);
            end
        end

        // R4: read every offset after the sweep.
        for (int off = 0; off < SIZE + 2; off++) do_fill("R4 read all", off);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule